// File: doc/BRIEF.md
# Paired Clock Divider Bank with Common Sync

This block takes a single fast clock and produces a set of divided clock outputs, arranged as pairs. Each pair has one divider and two outputs, A and B, which always share that divider's frequency. Each pair picks its division factor from the set 1, 2, 3, 4, 6, 8 and 16. Each of the two outputs can be inverted or gated off without affecting its partner. Every ratio, including the odd one, gives a 50% duty cycle. The divide-by-3 setting gets this by combining a rising-edge register with a falling-edge register.

A common hold input, `sync_req`, parks every divider. When it is released, all pairs start counting on the same input clock edge, so their rising edges line up. Ratio selections are captured only while the hold is active. A running pair therefore never has its period disturbed by a configuration write. Configuration arrives as plain parallel inputs, and the logic that loads them sits outside this block.

Top module: `clkdiv_bank`

## Requirements
- R1: The 3-bit ratio code of pair p sits at `ratio_sel[3p+2:3p]`. The codes map as follows: 000 gives /1, 001 gives /2, 010 gives /3, 011 gives /4, 100 gives /6, 101 gives /8, 110 gives /16 and 111 gives /1. An enabled, non-inverted output with ratio N has a period of N input cycles. It is high for the first N input half-cycles of each period, which is 50% duty for every N, /3 included.
- R2: The A and B outputs of a pair run at the same frequency and in the same phase when both are enabled and neither is inverted.
- R3: Output bit `out_inv[2p]` inverts `out_a[p]`, and `out_inv[2p+1]` inverts `out_b[p]`. Inversion acts on each output independently of its partner and takes effect without waiting for a clock edge.
- R4: An output whose enable bit (`out_en[2p]` for A, `out_en[2p+1]` for B) is low rests at its inversion bit: low when not inverted and high when inverted.
- R5: A change of enable takes effect only at a whole period boundary, so no shortened pulse ever appears. For ratio /1 the value seen at the falling clock edge gates the following high phase. For other ratios the value seen at the last rising edge of a period governs the whole next period.
- R6: While the hold (`sync_req` or `rst`) is high, every output sits at its idle level, which is its inversion bit. At the first rising clock edge where the hold is sampled low, every enabled, non-inverted output of every pair rises together.
- R7: A change of `ratio_sel` while the hold is low has no effect. The new ratio is captured at rising edges while the hold is high and applies from the next release.
- R8: Synchronous active-high `rst` has the same effect as `sync_req`: it clears every divider and captures the ratio codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset, acts as a hold |
| sync_req | input | 1 | Common hold; releasing it starts all dividers together |
| ratio_sel | input | 3*NUM_PAIRS | Ratio code per pair, 3 bits each |
| out_en | input | 2*NUM_PAIRS | Per-output enable, bit 2p for A and bit 2p+1 for B |
| out_inv | input | 2*NUM_PAIRS | Per-output inversion, same bit order as out_en |
| out_a | output | NUM_PAIRS | A output of each pair |
| out_b | output | NUM_PAIRS | B output of each pair |

## Verification
The bench builds the block with the default of five pairs. This allows five different ratios to run side by side in one run, including the odd /3, the pass-through /1 and the longest /16. Every output level is sampled in both halves of each input cycle, so the half-cycle duty of /3 and the gated pass-through of /1 are both checked. The five ratios all share a single release edge, which exercises the common start of R6 across very different counter lengths at once.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam int RATIO_W = 3;
    localparam int CNT_W   = 4;

    typedef enum logic [RATIO_W-1:0] {
        RT_D1   = 3'b000,
        RT_D2   = 3'b001,
        RT_D3   = 3'b010,
        RT_D4   = 3'b011,
        RT_D6   = 3'b100,
        RT_D8   = 3'b101,
        RT_D16  = 3'b110,
        RT_SPARE = 3'b111
    } ratio_e;

    // Decoded divider settings held per pair.
    typedef struct packed {
        logic [CNT_W-1:0] last;    // terminal count, N-1
        logic [CNT_W-1:0] half;    // count values below this give a high output
        logic             bypass;  // N == 1, the clock itself is passed through
        logic             odd;     // N == 3, half-cycle stretch is needed
    } div_cfg_t;

    // Signals from a pair's divider to its two output stages.
    typedef struct packed {
        logic hi;      // the coming period slot is a high slot
        logic wrap;    // the counter is at its terminal count
        logic bypass;
        logic odd;
    } pair_tap_t;

    function automatic int ratio_value(logic [RATIO_W-1:0] code);
        case (ratio_e'(code))
            RT_D2:   return 2;
            RT_D3:   return 3;
            RT_D4:   return 4;
            RT_D6:   return 6;
            RT_D8:   return 8;
            RT_D16:  return 16;
            default: return 1;
        endcase
    endfunction

    function automatic div_cfg_t decode_ratio(logic [RATIO_W-1:0] code);
        div_cfg_t cfg;
        int n;
        n          = ratio_value(code);
        cfg.last   = CNT_W'(n - 1);
        cfg.half   = CNT_W'(n / 2);
        cfg.bypass = (n == 1);
        cfg.odd    = (n == 3);
        return cfg;
    endfunction

endpackage

// File: rtl/clkdiv_pair_core.sv
`timescale 1ns/1ps
module clkdiv_pair_core
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [RATIO_W-1:0] ratio_code,
    output pair_tap_t          tap
);

    div_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q;

    // Ratio is only captured while the pair is parked.
    always_ff @(posedge clk) begin
        if (hold) begin
            cfg_q <= decode_ratio(ratio_code);
            cnt_q <= '0;
        end else if (cnt_q == cfg_q.last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tap.hi     = (cnt_q < cfg_q.half);
        tap.wrap   = (cnt_q == cfg_q.last);
        tap.bypass = cfg_q.bypass;
        tap.odd    = cfg_q.odd;
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        !hold |-> (cnt_q <= cfg_q.last))
        else $error("divider count beyond terminal value");

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !hold |=> $stable(cfg_q))
        else $error("ratio changed outside a hold");

    p_hold_clears_r6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt_q == '0))
        else $error("divider not parked by hold");

endmodule

// File: rtl/clkdiv_out_stage.sv
`timescale 1ns/1ps
module clkdiv_out_stage
    import clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  logic      en,
    input  logic      inv,
    input  pair_tap_t tap,
    output logic      y
);

    logic en_eff;   // enable frozen for the running period
    logic rise_q;   // rising-edge output register
    logic fall_q;   // falling-edge copy for the /3 stretch
    logic gate_q;   // falling-edge gate for the /1 pass-through
    logic raw;

    always_ff @(posedge clk) begin
        if (hold) begin
            rise_q <= 1'b0;
            en_eff <= en;
        end else begin
            rise_q <= en_eff & tap.hi;
            if (tap.wrap) en_eff <= en;
        end
    end

    always_ff @(negedge clk) begin
        if (hold) begin
            fall_q <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            fall_q <= rise_q;
            gate_q <= en;
        end
    end

    always_comb begin
        if (tap.bypass)   raw = clk & gate_q;
        else if (tap.odd) raw = rise_q | fall_q;
        else              raw = rise_q;
        y = raw ^ inv;
    end

    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!en_eff && !hold) |=> !rise_q)
        else $error("disabled output produced a pulse");

    p_enable_period_r5: assert property (@(posedge clk) disable iff (rst)
        (!hold && !tap.wrap) |=> $stable(en_eff))
        else $error("enable changed inside a period");

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        hold |=> !rise_q)
        else $error("output active during hold");

endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NUM_PAIRS = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sync_req,
    input  logic [RATIO_W*NUM_PAIRS-1:0] ratio_sel,
    input  logic [2*NUM_PAIRS-1:0]       out_en,
    input  logic [2*NUM_PAIRS-1:0]       out_inv,
    output logic [NUM_PAIRS-1:0]         out_a,
    output logic [NUM_PAIRS-1:0]         out_b
);

    localparam int NUM_OUTS = 2 * NUM_PAIRS;

    logic                  hold;
    logic [NUM_OUTS-1:0]   y_all;

    assign hold = rst | sync_req;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pair_tap_t tap;

        clkdiv_pair_core u_core (
            .clk        (clk),
            .rst        (rst),
            .hold       (hold),
            .ratio_code (ratio_sel[RATIO_W*p +: RATIO_W]),
            .tap        (tap)
        );

        for (genvar s = 0; s < 2; s++) begin : g_side
            clkdiv_out_stage u_stage (
                .clk  (clk),
                .rst  (rst),
                .hold (hold),
                .en   (out_en[2*p+s]),
                .inv  (out_inv[2*p+s]),
                .tap  (tap),
                .y    (y_all[2*p+s])
            );
        end

        assign out_a[p] = y_all[2*p];
        assign out_b[p] = y_all[2*p+1];
    end

    p_idle_level_r8: assert property (@(posedge clk)
        $past(rst) && rst && !out_en[0] |-> (out_a[0] == out_inv[0]))
        else $error("output not idle during reset");

endmodule

// File: tb/sim_clkdiv_bank.sv
`timescale 1ns/1ps
module sim_clkdiv_bank;

    localparam int NP = 5;
    localparam int NO = 2 * NP;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst, sync_req;
    logic [3*NP-1:0] ratio_sel;
    logic [NO-1:0]   out_en, out_inv;
    logic [NP-1:0]   out_a, out_b;

    clkdiv_bank #(.NUM_PAIRS(NP)) u0 (
        .clk(clk), .rst(rst), .sync_req(sync_req), .ratio_sel(ratio_sel),
        .out_en(out_en), .out_inv(out_inv), .out_a(out_a), .out_b(out_b)
    );

    // Staged stimulus, applied just after each rising edge.
    logic            s_rst, s_sync;
    logic [3*NP-1:0] s_ratio;
    logic [NO-1:0]   s_en, s_inv;

    // Behavioural reference state.
    int            ratio_m [NP];
    int            c_rel;
    bit            running;
    bit            en_per [NO];
    logic [NO-1:0] en_prev;
    bit            prev_hold;
    bit            skip_h;
    bit            active;
    string         req_tag;
    int            checks;
    int            fails;

    function automatic int code_to_n(logic [2:0] code);
        case (code)
            3'b001: return 2;
            3'b010: return 3;
            3'b011: return 4;
            3'b100: return 6;
            3'b101: return 8;
            3'b110: return 16;
            default: return 1;
        endcase
    endfunction

    task automatic compare(input int h);
        for (int o = 0; o < NO; o++) begin
            logic got, exp_v;
            int n, t;
            bit base;
            got = (o % 2 == 1) ? out_b[o/2] : out_a[o/2];
            base = 1'b0;
            if (running) begin
                n = ratio_m[o/2];
                t = 2 * c_rel + h;
                base = en_per[o] && ((t % (2*n)) < n);
            end
            exp_v = base ^ out_inv[o];
            checks++;
            if (got !== exp_v) begin
                fails++;
                $display("FAIL %s out%0d half%0d cycle%0d: got %0b expected %0b",
                         req_tag, o, h, c_rel, got, exp_v);
            end
        end
    endtask

    task automatic cycle();
        bit hold_s;
        @(posedge clk);
        hold_s = rst | sync_req;
        if (hold_s) begin
            running = 1'b0;
            for (int p = 0; p < NP; p++) ratio_m[p] = code_to_n(ratio_sel[3*p +: 3]);
            skip_h = !prev_hold;
        end else begin
            if (!running) begin
                running = 1'b1;
                c_rel = 0;
            end else begin
                c_rel++;
            end
            for (int o = 0; o < NO; o++) begin
                int n;
                n = ratio_m[o/2];
                if (c_rel % n == 0) en_per[o] = (n == 1) ? out_en[o] : en_prev[o];
            end
            skip_h = 1'b0;
        end
        en_prev   = out_en;
        prev_hold = hold_s;
        #0.5;
        rst = s_rst; sync_req = s_sync; ratio_sel = s_ratio;
        out_en = s_en; out_inv = s_inv;
        #0.5;
        if (active && !skip_h) compare(0);
        #2;
        if (active) compare(1);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired (all requirements): got hang expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        checks = 0; fails = 0; active = 0; running = 0; c_rel = 0;
        prev_hold = 1; skip_h = 0; en_prev = '0;
        for (int o = 0; o < NO; o++) en_per[o] = 0;
        req_tag = "R8 reset";
        // pair0 /1, pair1 /3, pair2 /16, pair3 /8, pair4 code 111 -> /1
        s_rst = 1; s_sync = 1;
        s_ratio = {3'b111, 3'b101, 3'b110, 3'b010, 3'b000};
        s_en = '1; s_inv = '0;
        rst = s_rst; sync_req = s_sync; ratio_sel = s_ratio;
        out_en = s_en; out_inv = s_inv;
        run(3);
        active = 1;
        req_tag = "R8 R6 idle after reset";
        run(2);
        s_rst = 0;
        run(3);
        req_tag = "R1 R2 R6 common release";
        s_sync = 0;
        run(48);
        req_tag = "R3 inversion";
        s_inv = 10'b10_0110_1001;
        run(34);
        s_inv = '0;
        req_tag = "R7 ratio ignored while running";
        s_ratio = {3'b001, 3'b001, 3'b001, 3'b001, 3'b001};
        run(34);
        req_tag = "R6 R1 resync with new ratios";
        s_ratio = {3'b010, 3'b000, 3'b100, 3'b011, 3'b001};
        s_sync = 1;
        run(3);
        s_sync = 0;
        run(50);
        req_tag = "R4 R5 enable changes";
        s_en = 10'b01_1010_0101;
        run(5);
        s_inv = 10'b00_0000_1010;
        run(7);
        s_en = 10'b11_0101_1110;
        run(3);
        s_en = '1;
        run(30);
        req_tag = "R8 reset mid-run";
        s_rst = 1;
        s_ratio = {3'b110, 3'b010, 3'b000, 3'b101, 3'b100};
        run(3);
        s_rst = 0;
        run(2);
        req_tag = "R1 R2 after reset release";
        run(48);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule